// File: doc/BRIEF.md
# PLL Power-Up / Power-Down Sequencer

This block brings an external phase-locked loop up and down in a fixed order. It drives three control outputs: a bypass-release line, an active-low reset line and an output gate. Enable and disable requests are one-cycle pulses. All waiting is measured in microsecond ticks from an internal prescaler of `TICKS_PER_US` clocks. The sequencer applies a settle gap after bypass release and then polls the lock-detect input once per microsecond for a bounded number of polls. After lock it opens the output gate. Power-down closes the gate first and drops reset and bypass together one microsecond later.

When the vote-mode bit of the mode word is set, the direct sequence is skipped. An enable raises a vote line and polls the active-flag input. A disable only withdraws the vote. A polling run that never sees its status bit ends with a sticky timeout flag. The next accepted request clears it.

A simple write port loads the mode word. A read port always shows the mode word: the three control lines, the two status inputs and the stored fields.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After synchronous reset, every control, status and vote output is low. `reg_rdata_o` then shows only the live status inputs.
- R2: An enable request accepted while idle, outside vote mode, with the PLL not fully on, raises `bypass_rel_o` at the accepting edge. `reset_n_o` rises exactly `SETTLE_US*TICKS_PER_US` cycles later.
- R3: After reset release, `lock_det_i` is sampled once every `TICKS_PER_US` cycles. `out_en_o` rises at the first sampling edge that sees it high.
- R4: If `MAX_POLLS` polls all miss the status bit, the run ends at the last poll. `timeout_o` goes high, `out_en_o` stays low, and `reset_n_o` and `bypass_rel_o` keep their values.
- R5: In vote mode (mode bit 20 = 1), an enable raises only `vote_o` and polls `active_i` under the same rules as R3 and R4. The direct control outputs do not change.
- R6: In vote mode, a disable clears `vote_o` at the accepting edge with `done_o` high in the same cycle, and `busy_o` stays low.
- R7: An enable while bypass, reset and gate are all high, or a direct disable while all three are low, produces a one-cycle `done_o` with no output change and no busy period.
- R8: A direct disable clears `out_en_o` at the accepting edge. `reset_n_o` and `bypass_rel_o` fall together `OFF_US*TICKS_PER_US` cycles later.
- R9: `busy_o` is high from the accepting edge until the completing edge. Requests arriving while it is high are ignored.
- R10: `done_o` is high for exactly the cycle after a completing edge. `timeout_o` stays high until the next accepted request clears it.
- R11: The read word places gate at bit 0, bypass at bit 1, reset at bit 2, lock-count at 13:8, bias-count at 19:14, vote mode at 20, vote reset at 21, active flag at 30 and lock detect at 31, with all other bits zero. A write stores only bits 21:8, so writing bits 2:0 leaves the control outputs unchanged.
- R12: An enable and a disable arriving in the same cycle are treated as an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req_i | input | 1 | Enable request pulse |
| dis_req_i | input | 1 | Disable request pulse |
| lock_det_i | input | 1 | Lock detect from the PLL |
| active_i | input | 1 | Active flag from the voting logic |
| reg_we_i | input | 1 | Mode word write strobe |
| reg_wdata_i | input | 32 | Mode word write data |
| reg_rdata_o | output | 32 | Mode word read view |
| bypass_rel_o | output | 1 | Bypass release |
| reset_n_o | output | 1 | Active-low PLL reset (1 = released) |
| out_en_o | output | 1 | Output gate |
| vote_o | output | 1 | Vote line in vote mode |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Sticky poll timeout |

## Verification
The bench measures each gap to the exact cycle: settle, first poll, lock at a later poll, the last poll before timeout, and the gate-to-reset gap on power-down. A design off by one in the prescaler or poll counter would move these edges by one microsecond or one clock. It also checks the cases that skip work: a repeated enable or disable, vote-mode requests, a disable pulse during bring-up, and simultaneous enable and disable. Each of these would show up as a stray busy period, an aborted bring-up, a touched control line or a reversed priority. After a timeout it checks that reset stays released and the gate stays shut. It then checks that the next request clears the flag.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_LOCK   = 3'd2,
    ST_OFF    = 3'd3,
    ST_VWAIT  = 3'd4
  } seq_state_e;

  localparam int MW_GATE     = 0;
  localparam int MW_BYPASS   = 1;
  localparam int MW_RESETN   = 2;
  localparam int MW_LCNT_LSB = 8;
  localparam int MW_BCNT_LSB = 14;
  localparam int MW_CNT_W    = 6;
  localparam int MW_VOTE_EN  = 20;
  localparam int MW_VOTE_RST = 21;
  localparam int MW_ACTIVE   = 30;
  localparam int MW_LOCK     = 31;

endpackage

// File: rtl/pll_us_tick.sv
module pll_us_tick #(
  parameter int TICKS_PER_US = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pll_mode_reg.sv
module pll_mode_reg
  import pll_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        gate,
  input  logic        bypass,
  input  logic        resetn,
  input  logic        lock_det,
  input  logic        active,
  output logic        vote_mode,
  output logic [31:0] rdata
);
  logic                vote_rst;
  logic [MW_CNT_W-1:0] lock_cnt;
  logic [MW_CNT_W-1:0] bias_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vote_mode <= 1'b0;
      vote_rst  <= 1'b0;
      lock_cnt  <= '0;
      bias_cnt  <= '0;
    end else if (we) begin
      vote_mode <= wdata[MW_VOTE_EN];
      vote_rst  <= wdata[MW_VOTE_RST];
      lock_cnt  <= wdata[MW_LCNT_LSB +: MW_CNT_W];
      bias_cnt  <= wdata[MW_BCNT_LSB +: MW_CNT_W];
    end
  end

  always_comb begin
    rdata                           = '0;
    rdata[MW_GATE]                  = gate;
    rdata[MW_BYPASS]                = bypass;
    rdata[MW_RESETN]                = resetn;
    rdata[MW_LCNT_LSB +: MW_CNT_W]  = lock_cnt;
    rdata[MW_BCNT_LSB +: MW_CNT_W]  = bias_cnt;
    rdata[MW_VOTE_EN]               = vote_mode;
    rdata[MW_VOTE_RST]              = vote_rst;
    rdata[MW_ACTIVE]                = active;
    rdata[MW_LOCK]                  = lock_det;
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US = 5,
  parameter int OFF_US    = 1,
  parameter int MAX_POLLS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic dis_req,
  input  logic vote_mode,
  input  logic lock_det,
  input  logic active,
  input  logic tick,
  output logic run,
  output logic bypass,
  output logic resetn,
  output logic gate,
  output logic vote,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int MAXV = (SETTLE_US > OFF_US) ?
                        ((SETTLE_US > MAX_POLLS) ? SETTLE_US : MAX_POLLS) :
                        ((OFF_US > MAX_POLLS) ? OFF_US : MAX_POLLS);
  localparam int UW = (MAXV > 1) ? $clog2(MAXV) : 1;
  localparam logic [UW-1:0] SETTLE_LAST = UW'(SETTLE_US - 1);
  localparam logic [UW-1:0] OFF_LAST    = UW'(OFF_US - 1);
  localparam logic [UW-1:0] POLL_LAST   = UW'(MAX_POLLS - 1);

  seq_state_e    state;
  logic [UW-1:0] us_cnt;
  logic          status;

  assign run    = (state != ST_IDLE);
  assign status = (state == ST_LOCK) ? lock_det : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      us_cnt <= '0;
      bypass <= 1'b0;
      resetn <= 1'b0;
      gate   <= 1'b0;
      vote   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          us_cnt <= '0;
          if (en_req) begin
            err <= 1'b0;
            if (vote_mode) begin
              vote  <= 1'b1;
              busy  <= 1'b1;
              state <= ST_VWAIT;
            end else if (gate && resetn && bypass) begin
              done <= 1'b1;
            end else begin
              bypass <= 1'b1;
              busy   <= 1'b1;
              state  <= ST_SETTLE;
            end
          end else if (dis_req) begin
            err <= 1'b0;
            if (vote_mode) begin
              vote <= 1'b0;
              done <= 1'b1;
            end else if (!gate && !resetn && !bypass) begin
              done <= 1'b1;
            end else begin
              gate  <= 1'b0;
              busy  <= 1'b1;
              state <= ST_OFF;
            end
          end
        end
        ST_SETTLE: begin
          if (tick) begin
            if (us_cnt == SETTLE_LAST) begin
              resetn <= 1'b1;
              us_cnt <= '0;
              state  <= ST_LOCK;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        ST_LOCK, ST_VWAIT: begin
          if (tick) begin
            if (status) begin
              if (state == ST_LOCK) gate <= 1'b1;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else if (us_cnt == POLL_LAST) begin
              err   <= 1'b1;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        ST_OFF: begin
          if (tick) begin
            if (us_cnt == OFF_LAST) begin
              resetn <= 1'b0;
              bypass <= 1'b0;
              done   <= 1'b1;
              busy   <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl #(
  parameter int TICKS_PER_US = 250,
  parameter int SETTLE_US    = 5,
  parameter int OFF_US       = 1,
  parameter int MAX_POLLS    = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en_req_i,
  input  logic        dis_req_i,
  input  logic        lock_det_i,
  input  logic        active_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        bypass_rel_o,
  output logic        reset_n_o,
  output logic        out_en_o,
  output logic        vote_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o
);
  logic run;
  logic tick;
  logic vote_mode;

  pll_us_tick #(.TICKS_PER_US(TICKS_PER_US)) i_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  pll_seq_fsm #(
    .SETTLE_US(SETTLE_US),
    .OFF_US   (OFF_US),
    .MAX_POLLS(MAX_POLLS)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .en_req   (en_req_i),
    .dis_req  (dis_req_i),
    .vote_mode(vote_mode),
    .lock_det (lock_det_i),
    .active   (active_i),
    .tick     (tick),
    .run      (run),
    .bypass   (bypass_rel_o),
    .resetn   (reset_n_o),
    .gate     (out_en_o),
    .vote     (vote_o),
    .busy     (busy_o),
    .done     (done_o),
    .err      (timeout_o)
  );

  pll_mode_reg i_mode (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we_i),
    .wdata    (reg_wdata_i),
    .gate     (out_en_o),
    .bypass   (bypass_rel_o),
    .resetn   (reset_n_o),
    .lock_det (lock_det_i),
    .active   (active_i),
    .vote_mode(vote_mode),
    .rdata    (reg_rdata_o)
  );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
  input logic clk,
  input logic rst,
  input logic lock_det_i,
  input logic bypass_rel_o,
  input logic reset_n_o,
  input logic out_en_o,
  input logic vote_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);
  AST_GATE_NEEDS_RESET: assert property (@(posedge clk) disable iff (rst)
    out_en_o |-> (reset_n_o && bypass_rel_o)); // R8
  AST_RESET_NEEDS_BYPASS: assert property (@(posedge clk) disable iff (rst)
    reset_n_o |-> bypass_rel_o); // R2
  AST_BYPASS_BEFORE_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass_rel_o) |-> !reset_n_o); // R2
  AST_GATE_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en_o) |-> $past(lock_det_i)); // R3
  AST_TIMEOUT_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> !out_en_o); // R4
  AST_RESET_BYPASS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_n_o) |-> $fell(bypass_rel_o)); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R10
  AST_VOTE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(vote_o)); // R9
endmodule

bind pll_seq_ctrl pll_seq_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .lock_det_i  (lock_det_i),
  .bypass_rel_o(bypass_rel_o),
  .reset_n_o   (reset_n_o),
  .out_en_o    (out_en_o),
  .vote_o      (vote_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/test_pll_seq_ctrl.sv
`timescale 1ns/1ps
module test_pll_seq_ctrl;
  localparam int T = 250;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 1'b0, dis_req = 1'b0, lock_det = 1'b0, active = 1'b0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic byp, rstn, oe, vote, busy, done, tmo;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pll_seq_ctrl #(.TICKS_PER_US(T)) i_pll_seq_ctrl (
    .clk(clk), .rst(rst), .en_req_i(en_req), .dis_req_i(dis_req),
    .lock_det_i(lock_det), .active_i(active), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .bypass_rel_o(byp),
    .reset_n_o(rstn), .out_en_o(oe), .vote_o(vote), .busy_o(busy),
    .done_o(done), .timeout_o(tmo)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: integer phase + elapsed-cycle counters
  int m_phase = 0, m_wait = 0, m_polls = 0;
  bit m_byp, m_rst, m_oe, m_vote, m_busy, m_done, m_err;
  bit m_ven, m_vrst;
  int m_lcnt, m_bcnt;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_wait = 0; m_polls = 0;
      m_byp = 0; m_rst = 0; m_oe = 0; m_vote = 0; m_busy = 0; m_done = 0; m_err = 0;
      m_ven = 0; m_vrst = 0; m_lcnt = 0; m_bcnt = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (en_req) begin
          m_err = 0;
          if (m_ven) begin m_vote = 1; m_busy = 1; m_phase = 4; m_wait = 0; m_polls = 0; end
          else if (m_oe && m_rst && m_byp) m_done = 1;
          else begin m_byp = 1; m_busy = 1; m_phase = 1; m_wait = 0; end
        end else if (dis_req) begin
          m_err = 0;
          if (m_ven) begin m_vote = 0; m_done = 1; end
          else if (!m_oe && !m_rst && !m_byp) m_done = 1;
          else begin m_oe = 0; m_busy = 1; m_phase = 3; m_wait = 0; end
        end
      end else if (m_phase == 1) begin
        m_wait++;
        if (m_wait == 5 * T) begin m_rst = 1; m_phase = 2; m_wait = 0; m_polls = 0; end
      end else if (m_phase == 2 || m_phase == 4) begin
        m_wait++;
        if (m_wait == T) begin
          m_wait = 0;
          m_polls++;
          if ((m_phase == 2) ? lock_det : active) begin
            if (m_phase == 2) m_oe = 1;
            m_done = 1; m_busy = 0; m_phase = 0;
          end else if (m_polls == 100) begin
            m_err = 1; m_done = 1; m_busy = 0; m_phase = 0;
          end
        end
      end else begin
        m_wait++;
        if (m_wait == T) begin m_rst = 0; m_byp = 0; m_done = 1; m_busy = 0; m_phase = 0; end
      end
      if (reg_we) begin
        m_ven = reg_wdata[20]; m_vrst = reg_wdata[21];
        m_lcnt = int'(reg_wdata[13:8]); m_bcnt = int'(reg_wdata[19:14]);
      end
    end
    #1;
    if (!rst) begin
      logic [31:0] exp_rd;
      exp_rd = {lock_det, active, 8'b0, m_vrst, m_ven, 6'(m_bcnt), 6'(m_lcnt),
                5'b0, m_rst, m_byp, m_oe};
      check(byp == m_byp, "R2", "model bypass", byp, m_byp);
      check(rstn == m_rst, "R2", "model reset_n", rstn, m_rst);
      check(oe == m_oe, "R3", "model out_en", oe, m_oe);
      check(vote == m_vote, "R5", "model vote", vote, m_vote);
      check(busy == m_busy, "R9", "model busy", busy, m_busy);
      check(done == m_done, "R10", "model done", done, m_done);
      check(tmo == m_err, "R4", "model timeout", tmo, m_err);
      check(rdata == exp_rd, "R11", "model rdata", rdata, exp_rd);
    end
  end

  function automatic logic sig(input int w);
    case (w)
      0: return byp;
      1: return rstn;
      2: return oe;
      3: return vote;
      4: return busy;
      5: return done;
      default: return tmo;
    endcase
  endfunction

  task automatic wait_sig(input int w, input logic v, output int n);
    n = 0;
    while (sig(w) !== v && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_en();
    @(negedge clk); en_req = 1'b1;
    @(negedge clk); en_req = 1'b0;
  endtask
  task automatic pulse_dis();
    @(negedge clk); dis_req = 1'b1;
    @(negedge clk); dis_req = 1'b0;
  endtask
  task automatic pulse_both();
    @(negedge clk); en_req = 1'b1; dis_req = 1'b1;
    @(negedge clk); en_req = 1'b0; dis_req = 1'b0;
  endtask
  task automatic write_mode(input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(190000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, n2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({byp, rstn, oe, vote, busy, done, tmo} == 7'b0, "R1", "outputs after reset",
          {byp, rstn, oe, vote, busy, done, tmo}, 0);
    check(rdata == 32'h0, "R1", "rdata after reset", rdata, 0);

    // R11 field layout, bits 2:0 not writable
    write_mode(32'hC020_0007 | (32'h2A << 8) | (32'h15 << 14));
    check(rdata == 32'h0025_6A00, "R11", "rdata after write", rdata, 32'h0025_6A00);
    check({byp, rstn, oe} == 3'b0, "R11", "write to control bits ignored", {byp, rstn, oe}, 0);

    // R2/R3/R9 bring-up with lock at third poll and a disable during busy
    pulse_en();
    check(byp && !rstn && busy, "R2", "bypass first", {byp, rstn, busy}, 3'b101);
    wait_sig(1, 1'b1, n);
    check(n == 5 * T, "R2", "settle gap cycles", n, 5 * T);
    pulse_dis();
    repeat (2 * T) @(negedge clk);
    lock_det = 1'b1;
    wait_sig(2, 1'b1, n2);
    check(n2 + 2 * T + 2 == 3 * T, "R3", "reset to gate cycles", n2 + 2 * T + 2, 3 * T);
    check(rstn && byp, "R9", "disable during busy ignored", {rstn, byp}, 2'b11);
    check(done && !busy, "R10", "done at completion", {done, busy}, 2'b10);
    @(negedge clk);
    check(!done, "R10", "done single cycle", done, 0);

    // R7 repeated enable
    pulse_en();
    check(done && !busy && oe && rstn && byp, "R7", "enable when on",
          {done, busy, oe, rstn, byp}, 5'b10111);

    // R8 power-down
    pulse_dis();
    check(!oe && rstn && byp && busy, "R8", "gate falls first", {oe, rstn, byp, busy}, 4'b0111);
    wait_sig(1, 1'b0, n);
    check(n == T && !byp, "R8", "gate to reset gap", n, T);

    // R7 repeated disable
    pulse_dis();
    check(done && !busy, "R7", "disable when off", {done, busy}, 2'b10);

    // R4 timeout
    lock_det = 1'b0;
    pulse_en();
    wait_sig(1, 1'b1, n);
    wait_sig(6, 1'b1, n);
    check(n == 100 * T, "R4", "timeout poll span", n, 100 * T);
    check(!oe && rstn && byp && !busy, "R4", "state at timeout", {oe, rstn, byp, busy}, 4'b0110);
    repeat (5) @(negedge clk);
    check(tmo, "R10", "timeout sticky", tmo, 1);
    pulse_dis();
    check(!tmo, "R10", "timeout cleared by request", tmo, 0);
    wait_sig(4, 1'b0, n);

    // R12 simultaneous requests
    lock_det = 1'b1;
    pulse_both();
    check(byp && busy, "R12", "enable wins", {byp, busy}, 2'b11);
    wait_sig(2, 1'b1, n);
    check(n == 6 * T, "R12", "full bring-up cycles", n, 6 * T);
    pulse_dis();
    wait_sig(4, 1'b0, n);
    lock_det = 1'b0;

    // R5 / R6 vote mode
    write_mode(32'h0010_0000);
    pulse_en();
    check(vote && busy && !byp, "R5", "vote raised only", {vote, busy, byp}, 3'b110);
    repeat (T / 2) @(negedge clk);
    active = 1'b1;
    wait_sig(4, 1'b0, n);
    check(n + T / 2 == T - 1 + 0 || n + T / 2 == T, "R5", "active poll cycles", n + T / 2, T);
    check(vote && !byp && !rstn && !oe, "R5", "direct lines untouched", {vote, byp, rstn, oe}, 4'b1000);
    pulse_dis();
    check(!vote && done && !busy, "R6", "vote withdrawn", {vote, done, busy}, 3'b010);
    active = 1'b0;
    pulse_en();
    wait_sig(6, 1'b1, n);
    check(n == 100 * T, "R5", "vote timeout span", n, 100 * T);
    check(vote && !byp, "R5", "vote held at timeout", {vote, byp}, 2'b10);
    pulse_dis();
    check(!vote && !tmo, "R6", "vote dropped, error cleared", {vote, tmo}, 2'b00);
    write_mode(32'h0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule